// File: doc/BRIEF.md
# Dual-Line Interrupt Controller

This block gathers up to 32 interrupt sources and presents them to a processor on two request lines plus a wake line. Each source picks between two raw inputs. The chosen input passes through a two-stage synchroniser. It is then judged by a 3-bit trigger code. The code gives rising-edge, falling-edge, both-edge, active-high level or active-low level triggering, or turns the source off. Edge events are held in capture flags until software clears them. Level sources follow the synchronised input directly.

Software programs the block over a simple word-addressed register bus. Every control register is changed through a pair of addresses. One address sets the bits written as 1, and the other clears them, so no read-modify-write is needed. A mask bit allows a source to request. A route bit picks which request line it drives. A wake-enable bit lets it drive the wake line whether or not it is masked. Priority between sources is decided by software, which reads one pending register per request line.

Top module: `dual_line_intc`

## Requirements
- R1: The 3-bit code for a source is {cfg2,cfg1,cfg0}. The codes are: 3'b001 rising edge, 3'b010 falling edge, 3'b011 either edge, 3'b101 active-high level, 3'b110 active-low level. A source coded 3'b000, 3'b100 or 3'b111 never asserts.
- R2: The register word addresses pair up as set and clear. cfg0 uses 0/1, cfg1 uses 2/3 and cfg2 uses 4/5. Route uses 6/7, source-select 8/9, mask 10/11 and wake-enable 12/13. A write to a set address ORs the data into the register, and a write to a clear address removes the bits written as 1. Bits written as 0 keep their value. A read of either address of a pair returns that register.
- R3: A masked, asserting source whose route bit is 1 drives `req0_o`. One whose route bit is 0 drives `req1_o`.
- R4: A 0-to-1 change of a source in code 001 or 011 sets its rising flag. A 1-to-0 change in code 010 or 011 sets its falling flag. A flag stays set after the input returns. Writing 1 to address 14 clears rising flags, and writing 1 to address 15 clears falling flags. Reads of 14 and 15 return the rising and falling flags.
- R5: A source whose mask bit is 0 drives neither request line and shows in neither pending register.
- R6: Reading address 16 returns the sources that are asserting, masked and routed to `req0_o`. Reading address 17 does the same for `req1_o`.
- R7: `wake_o` is high when any source is asserting with its wake-enable bit set, regardless of its mask bit.
- R8: A source-select bit of 1 takes that source from `dev_irq_i`, and 0 takes it from `pad_irq_i`.
- R9: A level source reaches the request output on the second rising clock edge after its input changes. An edge source reaches it on the third.
- R10: After reset every register and flag reads 0, and `req0_o`, `req1_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register word address |
| bus_wdata_i | input | 32 | Write data, one bit per source |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| dev_irq_i | input | 32 | Raw on-chip source inputs |
| pad_irq_i | input | 32 | Raw pin source inputs |
| req0_o | output | 1 | Processor interrupt request line 0 |
| req1_o | output | 1 | Processor interrupt request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
On every cycle, the assertions check three things. The first is the effect of each set or clear write on the mask register. The second is that a detected edge lands in its capture flag. The third is that disabled and unused codes never assert. They also check that an all-zero mask keeps both request lines low, that routing everything to line 0 keeps line 1 quiet, and that the wake line needs an enabled source. The directed scenarios cover what needs a chosen sequence of stimulus. This includes each trigger code and its clearing path, the exact two- and three-edge latencies, input selection, and the pending registers read over the bus.

// File: rtl/intc_pkg.sv
// Shared definitions for the dual-line interrupt controller.
// Assumes a 5-bit word address; control registers sit in set/clear pairs.
package intc_pkg;

    localparam int ADDR_W = 5;

    // Index of each paired control register (address = 2*index + is_clear).
    localparam int CTL_CFG0  = 0;
    localparam int CTL_CFG1  = 1;
    localparam int CTL_CFG2  = 2;
    localparam int CTL_ROUTE = 3;
    localparam int CTL_SRC   = 4;
    localparam int CTL_MASK  = 5;
    localparam int CTL_WAKE  = 6;
    localparam int CTL_COUNT = 7;

    // Word addresses outside the paired block.
    localparam logic [ADDR_W-1:0] A_RISE_CLR = 5'd14;
    localparam logic [ADDR_W-1:0] A_FALL_CLR = 5'd15;
    localparam logic [ADDR_W-1:0] A_PEND0    = 5'd16;
    localparam logic [ADDR_W-1:0] A_PEND1    = 5'd17;

    // Trigger codes {cfg2,cfg1,cfg0}.
    typedef enum logic [2:0] {
        TRIG_OFF   = 3'b000,
        TRIG_RISE  = 3'b001,
        TRIG_FALL  = 3'b010,
        TRIG_BOTH  = 3'b011,
        TRIG_HIGH  = 3'b101,
        TRIG_LOW   = 3'b110
    } trig_e;

endpackage

// File: rtl/intc_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is promised.
module intc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage re-samples the one before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/intc_detect.sv
// Per-source trigger evaluation: edge capture flags and level following.
// Assumes lvl_i is already synchronous; flag set wins over a same-cycle clear.
module intc_detect
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] cfg0_i,
    input  logic [N-1:0] cfg1_i,
    input  logic [N-1:0] cfg2_i,
    input  logic [N-1:0] rise_clr_i,
    input  logic [N-1:0] fall_clr_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o,
    output logic [N-1:0] active_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] rise_ev;
    logic [N-1:0] fall_ev;
    logic [N-1:0] code_dead;

    // Delay line used to spot transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        trig_e code;
        assign code = trig_e'({cfg2_i[i], cfg1_i[i], cfg0_i[i]});
        assign rise_ev[i] = lvl_i[i] & ~prev_q[i] &
                            ((code == TRIG_RISE) || (code == TRIG_BOTH));
        assign fall_ev[i] = ~lvl_i[i] & prev_q[i] &
                            ((code == TRIG_FALL) || (code == TRIG_BOTH));

        // Rising capture flag: set by an event, cleared by software.
        always_ff @(posedge clk) begin
            if (!rst_n)             rise_o[i] <= 1'b0;
            else if (rise_ev[i])    rise_o[i] <= 1'b1;
            else if (rise_clr_i[i]) rise_o[i] <= 1'b0;
        end

        // Falling capture flag: set by an event, cleared by software.
        always_ff @(posedge clk) begin
            if (!rst_n)             fall_o[i] <= 1'b0;
            else if (fall_ev[i])    fall_o[i] <= 1'b1;
            else if (fall_clr_i[i]) fall_o[i] <= 1'b0;
        end

        // Decode whether this source is currently asserting.
        always_comb begin
            unique case (code)
                TRIG_RISE: active_o[i] = rise_o[i];
                TRIG_FALL: active_o[i] = fall_o[i];
                TRIG_BOTH: active_o[i] = rise_o[i] | fall_o[i];
                TRIG_HIGH: active_o[i] = lvl_i[i];
                TRIG_LOW:  active_o[i] = ~lvl_i[i];
                default:   active_o[i] = 1'b0;
            endcase
        end
    end

    assign code_dead = ~(cfg2_i | cfg1_i | cfg0_i) | (cfg2_i & ~(cfg1_i ^ cfg0_i));

    // R4
    rise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_ev) |=> ((rise_o & $past(rise_ev)) == $past(rise_ev)));

    // R4
    fall_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_ev) |=> ((fall_o & $past(fall_ev)) == $past(fall_ev)));

    // R1
    dead_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_dead & active_o) == '0);
endmodule

// File: rtl/intc_regs.sv
// Register bank: paired set/clear control registers and the read mux.
// Assumes single-cycle writes; reads are combinational from the address.
module intc_regs
    import intc_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    output logic [N-1:0]      rdata_o,
    input  logic [N-1:0]      rise_i,
    input  logic [N-1:0]      fall_i,
    input  logic [N-1:0]      pend0_i,
    input  logic [N-1:0]      pend1_i,
    output logic [N-1:0]      ctl_o [CTL_COUNT],
    output logic [N-1:0]      rise_clr_o,
    output logic [N-1:0]      fall_clr_o
);
    localparam int PAIR_W = ADDR_W - 1;
    localparam int PAIR_TOP = 2 * CTL_COUNT;

    logic [N-1:0] ctl_q [CTL_COUNT];
    logic         in_pairs;
    logic [PAIR_W-1:0] pair_idx;

    assign in_pairs = (int'(addr_i) < PAIR_TOP);
    assign pair_idx = addr_i[ADDR_W-1:1];

    for (genvar r = 0; r < CTL_COUNT; r++) begin : g_ctl
        // Apply set or clear writes addressed to this register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ctl_q[r] <= '0;
            else if (wr_i && in_pairs && (int'(pair_idx) == r))
                ctl_q[r] <= addr_i[0] ? (ctl_q[r] & ~wdata_i) : (ctl_q[r] | wdata_i);
        end
        assign ctl_o[r] = ctl_q[r];
    end

    assign rise_clr_o = (wr_i && addr_i == A_RISE_CLR) ? wdata_i : '0;
    assign fall_clr_o = (wr_i && addr_i == A_FALL_CLR) ? wdata_i : '0;

    // Select read data by address.
    always_comb begin
        rdata_o = '0;
        if (in_pairs)                 rdata_o = ctl_q[pair_idx];
        else if (addr_i == A_RISE_CLR) rdata_o = rise_i;
        else if (addr_i == A_FALL_CLR) rdata_o = fall_i;
        else if (addr_i == A_PEND0)    rdata_o = pend0_i;
        else if (addr_i == A_PEND1)    rdata_o = pend1_i;
    end

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 5'(2*CTL_MASK)) |=>
        ((ctl_q[CTL_MASK] & $past(wdata_i)) == $past(wdata_i)));

    // R2
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == 5'(2*CTL_MASK+1)) |=>
        ((ctl_q[CTL_MASK] & $past(wdata_i)) == '0));
endmodule

// File: rtl/dual_line_intc.sv
// Top of the dual-line interrupt controller: input select, synchroniser,
// trigger detection, masking, routing to two request lines and wake.
// Assumes 32 sources by default and a 5-bit word-addressed register bus.
module dual_line_intc
    import intc_pkg::*;
#(
    parameter int N_SRC = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [4:0]        bus_addr_i,
    input  logic [N_SRC-1:0]  bus_wdata_i,
    output logic [N_SRC-1:0]  bus_rdata_o,
    input  logic [N_SRC-1:0]  dev_irq_i,
    input  logic [N_SRC-1:0]  pad_irq_i,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);
    logic [N_SRC-1:0] ctl [CTL_COUNT];
    logic [N_SRC-1:0] raw_sel;
    logic [N_SRC-1:0] synced;
    logic [N_SRC-1:0] rise_flags;
    logic [N_SRC-1:0] fall_flags;
    logic [N_SRC-1:0] rise_clr;
    logic [N_SRC-1:0] fall_clr;
    logic [N_SRC-1:0] active;
    logic [N_SRC-1:0] pend0;
    logic [N_SRC-1:0] pend1;

    // Choose each source's raw input by its source-select bit.
    assign raw_sel = (ctl[CTL_SRC] & dev_irq_i) | (~ctl[CTL_SRC] & pad_irq_i);

    intc_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_sel),
        .q_o   (synced)
    );

    intc_detect #(.N(N_SRC)) detect_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (synced),
        .cfg0_i     (ctl[CTL_CFG0]),
        .cfg1_i     (ctl[CTL_CFG1]),
        .cfg2_i     (ctl[CTL_CFG2]),
        .rise_clr_i (rise_clr),
        .fall_clr_i (fall_clr),
        .rise_o     (rise_flags),
        .fall_o     (fall_flags),
        .active_o   (active)
    );

    intc_regs #(.N(N_SRC)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .rdata_o    (bus_rdata_o),
        .rise_i     (rise_flags),
        .fall_i     (fall_flags),
        .pend0_i    (pend0),
        .pend1_i    (pend1),
        .ctl_o      (ctl),
        .rise_clr_o (rise_clr),
        .fall_clr_o (fall_clr)
    );

    // Mask and steer active sources to their request line.
    assign pend0  = active & ctl[CTL_MASK] &  ctl[CTL_ROUTE];
    assign pend1  = active & ctl[CTL_MASK] & ~ctl[CTL_ROUTE];
    assign req0_o = |pend0;
    assign req1_o = |pend1;
    assign wake_o = |(active & ctl[CTL_WAKE]);

    // R5
    mask_gates_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CTL_MASK] == '0) |-> (!req0_o && !req1_o));

    // R3
    route_all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[CTL_ROUTE] == '1) |-> !req1_o);

    // R7
    wake_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (ctl[CTL_WAKE] != '0));
endmodule

// File: tb/dual_line_intc_tb_top.sv
// Directed bench for dual_line_intc; each scenario task checks its results.
module dual_line_intc_tb_top;
    localparam logic [4:0] CFG0_S = 5'd0, CFG0_C = 5'd1, CFG1_S = 5'd2, CFG1_C = 5'd3;
    localparam logic [4:0] CFG2_S = 5'd4, CFG2_C = 5'd5, RT_S = 5'd6, RT_C = 5'd7;
    localparam logic [4:0] SRC_S = 5'd8, SRC_C = 5'd9, MSK_S = 5'd10, MSK_C = 5'd11;
    localparam logic [4:0] WK_S = 5'd12, WK_C = 5'd13, RCLR = 5'd14, FCLR = 5'd15;
    localparam logic [4:0] PND0 = 5'd16, PND1 = 5'd17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] dev_irq = '0;
    logic [31:0] pad_irq = '0;
    logic        req0, req1, wake;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_line_intc dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .dev_irq_i(dev_irq),
        .pad_irq_i(pad_irq), .req0_o(req0), .req1_o(req1), .wake_o(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_code(input int idx, input logic [2:0] code);
        wr(code[0] ? CFG0_S : CFG0_C, 32'd1 << idx);
        wr(code[1] ? CFG1_S : CFG1_C, 32'd1 << idx);
        wr(code[2] ? CFG2_S : CFG2_C, 32'd1 << idx);
    endtask

    task automatic cleanup();
        wr(MSK_C, '1); wr(WK_C, '1); wr(RT_C, '1); wr(SRC_C, '1);
        wr(CFG0_C, '1); wr(CFG1_C, '1); wr(CFG2_C, '1);
        pad_irq = '0; dev_irq = '0;
        idle(4);
        wr(RCLR, '1); wr(FCLR, '1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        pad_irq = '1; dev_irq = '1;
        idle(4);
        chk("R10 req0", {31'd0, req0}, 0);
        chk("R10 req1", {31'd0, req1}, 0);
        chk("R10 wake", {31'd0, wake}, 0);
        rd(MSK_S, d); chk("R10 mask", d, 0);
        rd(CFG0_C, d); chk("R10 cfg0", d, 0);
        rd(PND0, d); chk("R10 pend0", d, 0);
        chk("R1 off code quiet", {30'd0, req0, req1}, 0);
        pad_irq = '0; dev_irq = '0;
        idle(4);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(MSK_S, 32'h1); wr(MSK_S, 32'h2);
        rd(MSK_C, d); chk("R2 set keeps zeros", d, 32'h3);
        wr(MSK_C, 32'h1);
        rd(MSK_S, d); chk("R2 clear one bit", d, 32'h2);
        wr(RT_S, 32'hF0F0_0000);
        rd(RT_C, d); chk("R2 route readback", d, 32'hF0F0_0000);
        cleanup();
    endtask

    task automatic t_edges();
        logic [31:0] d;
        set_code(3, 3'b001); set_code(4, 3'b010); set_code(5, 3'b011);
        wr(RT_S, 32'h08); wr(MSK_S, 32'h38);
        pad_irq[3] = 1'b1; idle(4);
        chk("R4 rise asserts req0", {31'd0, req0}, 1);
        rd(RCLR, d); chk("R4 rise flag", d, 32'h08);
        pad_irq[3] = 1'b0; idle(4);
        chk("R4 rise latched", {31'd0, req0}, 1);
        wr(RCLR, 32'h08); idle(1);
        chk("R4 rise cleared", {31'd0, req0}, 0);
        pad_irq[4] = 1'b1; idle(4);
        chk("R4 no rise in fall mode", {31'd0, req1}, 0);
        pad_irq[4] = 1'b0; idle(4);
        chk("R4 fall asserts req1", {31'd0, req1}, 1);
        rd(PND1, d); chk("R6 pend1 fall", d, 32'h10);
        wr(FCLR, 32'h10); idle(1);
        chk("R4 fall cleared", {31'd0, req1}, 0);
        pad_irq[5] = 1'b1; idle(4);
        chk("R1 both rise", {31'd0, req1}, 1);
        wr(RCLR, 32'h20); idle(1);
        pad_irq[5] = 1'b0; idle(4);
        chk("R1 both fall", {31'd0, req1}, 1);
        rd(FCLR, d); chk("R4 both fall flag", d, 32'h20);
        cleanup();
    endtask

    task automatic t_levels();
        logic [31:0] d;
        set_code(6, 3'b101); set_code(7, 3'b110);
        set_code(8, 3'b111); set_code(13, 3'b100);
        wr(RT_S, 32'h40); wr(MSK_S, 32'h21C0);
        pad_irq[8] = 1'b1; pad_irq[13] = 1'b1;
        idle(4);
        chk("R1 low level asserts", {31'd0, req1}, 1);
        chk("R1 high level idle", {31'd0, req0}, 0);
        rd(PND1, d); chk("R1 unused codes quiet", d, 32'h80);
        pad_irq[6] = 1'b1; pad_irq[7] = 1'b1; idle(4);
        chk("R1 high level follows", {31'd0, req0}, 1);
        chk("R1 low level released", {31'd0, req1}, 0);
        rd(PND0, d); chk("R6 pend0", d, 32'h40);
        wr(MSK_C, 32'h40); idle(1);
        chk("R5 mask off req0", {31'd0, req0}, 0);
        rd(PND0, d); chk("R5 mask off pend0", d, 0);
        wr(WK_S, 32'h40); idle(1);
        chk("R7 wake unmasked", {31'd0, wake}, 1);
        pad_irq[6] = 1'b0; idle(4);
        chk("R7 wake follows", {31'd0, wake}, 0);
        cleanup();
    endtask

    task automatic t_route();
        set_code(12, 3'b101); wr(MSK_S, 32'h1000);
        pad_irq[12] = 1'b1; idle(4);
        chk("R3 route0 bit clear -> req1", {30'd0, req0, req1}, 32'h1);
        wr(RT_S, 32'h1000); idle(1);
        chk("R3 route bit set -> req0", {30'd0, req0, req1}, 32'h2);
        cleanup();
    endtask

    task automatic t_srcsel();
        set_code(11, 3'b101); wr(MSK_S, 32'h800); wr(RT_S, 32'h800);
        dev_irq[11] = 1'b1; idle(4);
        chk("R8 pad chosen by default", {31'd0, req0}, 0);
        wr(SRC_S, 32'h800); idle(4);
        chk("R8 dev chosen", {31'd0, req0}, 1);
        cleanup();
    endtask

    task automatic t_latency();
        set_code(9, 3'b101); set_code(10, 3'b001);
        wr(RT_S, 32'h600); wr(MSK_S, 32'h600);
        @(negedge clk); pad_irq[9] = 1'b1;
        @(posedge clk); #1 chk("R9 level after 1 edge", {31'd0, req0}, 0);
        @(posedge clk); #1 chk("R9 level after 2 edges", {31'd0, req0}, 1);
        @(negedge clk); pad_irq[9] = 1'b0; idle(4);
        @(negedge clk); pad_irq[10] = 1'b1;
        @(posedge clk); @(posedge clk);
        #1 chk("R9 edge after 2 edges", {31'd0, req0}, 0);
        @(posedge clk); #1 chk("R9 edge after 3 edges", {31'd0, req0}, 1);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_edges();
        t_levels();
        t_route();
        t_srcsel();
        t_latency();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule